// File: doc/BRIEF.md
# Display Memory Write Address Generator

This block turns a stream of host pixel-byte writes into physical addresses for a 1-bit-per-pixel display memory. The memory is arranged as horizontal bands (pages), each a row of 8-bit vertical slices, one slice per pixel column. The host first places the cursor with a page-load strobe and a column-load strobe. It then sends data bytes. After each byte the cursor moves one column to the right. At the right edge the cursor either stays put or drops into the adjacent page, depending on the mode.

A four-bit mode register, loaded through its own strobe, sets four behaviours. One bit enables wrap at the row end. One bit picks whether that wrap steps the page up or down. One bit mirrors the column horizontally. One bit reverses the bit order of the stored byte. Every data strobe produces one registered write: a write enable, a linear memory byte address and the reordered data byte. The memory array, display refresh and command decoding sit outside the block.

Top module: `dram_addr_gen`

## Requirements
- R1: Synchronous active-high reset sets page 0 and column 0 and clears all four mode bits. While reset is held, `ram_we` is 0.
- R2: A page-load strobe sets the page to its value, clamped to 19. A column-load strobe sets the column to its value, clamped to 239. The page and column are therefore never above 19 and 239.
- R3: A data strobe advances the column by one at the next clock edge. Load strobes and mode strobes never advance the cursor, and idle cycles leave it unchanged. When a load strobe arrives together with a data strobe, the loaded value wins over the advance. The write in that cycle still uses the old cursor.
- R4: With the wrap bit (mode bit 0) at 0, a data strobe at column 239 leaves both column and page unchanged.
- R5: With the wrap bit at 1, a data strobe at column 239 sets the column to 0. The page then moves up by one if the direction bit (mode bit 1) is 0, and down by one if it is 1.
- R6: A page step up from 19 gives 0, and a page step down from 0 gives 19.
- R7: With the mirror bit (mode bit 2) at 0, column c addresses byte c of its page. With the mirror bit at 1, it addresses byte 239-c.
- R8: With the bit-order bit (mode bit 3) at 0, the data byte is stored unchanged. With that bit at 1, bit i of the input lands in bit 7-i of the stored byte.
- R9: One cycle after each data strobe, `ram_we` is 1 for exactly one cycle. In that cycle `ram_addr` = page*240 + mapped column, using the page, column and mode held before that edge. `ram_we` is 0 in every other cycle.
- R10: A mode strobe loads all four mode bits from `cfg_val` at the next edge. The new mode first affects the data strobe after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_stb | input | 1 | Load mode register |
| cfg_val | input | 4 | Mode bits: [0] wrap, [1] page down, [2] mirror, [3] reverse bits |
| set_page_stb | input | 1 | Load page |
| set_page_val | input | 5 | Page value (clamped to 19) |
| set_col_stb | input | 1 | Load column |
| set_col_val | input | 8 | Column value (clamped to 239) |
| wr_stb | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte from host |
| ram_we | output | 1 | Registered memory write enable |
| ram_addr | output | 13 | Registered linear byte address |
| ram_wdata | output | 8 | Registered reordered data byte |
| cur_page | output | 5 | Current page |
| cur_col | output | 8 | Current logical column |

## Verification
The embedded properties assume the strobes are synchronous single-cycle levels sampled at the rising edge. They also assume `rst` clears the state before any property is evaluated. They do not rely on strobes being exclusive. The stepping properties exclude the load-strobe cycles themselves, so load and data strobes may coincide. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It also includes a deliberate coincident load-and-write cycle, which exercises the priority case.

// File: rtl/dram_pkg.sv
package dram_pkg;

  // Mode register layout; bit positions are fixed by the host-visible encoding.
  typedef struct packed {
    logic rev_bits;   // [3] reverse data bit order
    logic mirror;     // [2] mirror column index
    logic page_down;  // [1] page steps downward on wrap
    logic wrap;       // [0] wrap at row end
  } mode_t;

  localparam mode_t MODE_RESET = '0;

endpackage

// File: rtl/dram_cursor.sv
module dram_cursor #(
  parameter int PAGES = 20,
  parameter int COLS  = 240,
  localparam int PW   = $clog2(PAGES),
  localparam int CW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_page,
  input  logic [PW-1:0] ld_page_val,
  input  logic          ld_col,
  input  logic [CW-1:0] ld_col_val,
  input  logic          adv,
  input  logic          wrap_en,
  input  logic          step_down,
  output logic [PW-1:0] page,
  output logic [CW-1:0] col
);

  localparam logic [PW-1:0] PMAX = PW'(PAGES - 1);
  localparam logic [CW-1:0] CMAX = CW'(COLS - 1);

  logic          any_ld;
  logic          at_end;
  logic [PW-1:0] page_clamped;
  logic [CW-1:0] col_clamped;
  logic [PW-1:0] page_stepped;
  logic [PW-1:0] page_nxt;
  logic [CW-1:0] col_nxt;

  assign any_ld       = ld_page | ld_col;
  assign at_end       = (col == CMAX);
  assign page_clamped = (ld_page_val > PMAX) ? PMAX : ld_page_val;
  assign col_clamped  = (ld_col_val  > CMAX) ? CMAX : ld_col_val;

  always_comb begin
    if (step_down) page_stepped = (page == '0)  ? PMAX : page - PW'(1);
    else           page_stepped = (page == PMAX) ? '0  : page + PW'(1);
  end

  always_comb begin
    page_nxt = page;
    col_nxt  = col;
    if (any_ld) begin
      if (ld_page) page_nxt = page_clamped;
      if (ld_col)  col_nxt  = col_clamped;
    end else if (adv) begin
      if (!at_end) begin
        col_nxt = col + CW'(1);
      end else if (wrap_en) begin
        col_nxt  = '0;
        page_nxt = page_stepped;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      col  <= '0;
    end else begin
      page <= page_nxt;
      col  <= col_nxt;
    end
  end

  assert_page_range_R2: assert property (@(posedge clk) disable iff (rst)
    page <= PMAX);
  assert_col_range_R2: assert property (@(posedge clk) disable iff (rst)
    col <= CMAX);
  assert_col_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_ld && col != CMAX) |=> (col == $past(col) + CW'(1)) && $stable(page));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!adv && !any_ld) |=> $stable(col) && $stable(page));
  assert_col_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_ld && !wrap_en && col == CMAX) |=> (col == CMAX) && $stable(page));
  assert_col_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_ld && wrap_en && col == CMAX) |=> (col == '0) && !$stable(page));
  assert_page_top_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_ld && wrap_en && !step_down && col == CMAX && page == PMAX) |=> page == '0);
  assert_page_bot_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_ld && wrap_en && step_down && col == CMAX && page == '0) |=> page == PMAX);

endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int PAGES = 20,
  parameter int COLS  = 240,
  localparam int PW   = $clog2(PAGES),
  localparam int CW   = $clog2(COLS),
  localparam int AW   = $clog2(PAGES * COLS)
) (
  input  logic [PW-1:0] page,
  input  logic [CW-1:0] col,
  input  logic          mirror,
  output logic [AW-1:0] addr
);

  localparam logic [CW-1:0] CMAX = CW'(COLS - 1);

  logic [CW-1:0] phys_col;
  logic [AW-1:0] page_base;

  assign phys_col  = mirror ? (CMAX - col) : col;
  assign page_base = AW'(page) * AW'(COLS);
  assign addr      = page_base + AW'(phys_col);

endmodule

// File: rtl/dram_bit_order.sv
module dram_bit_order #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          reverse,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] flipped;

  for (genvar i = 0; i < DW; i++) begin : g_flip
    assign flipped[i] = din[DW-1-i];
  end

  assign dout = reverse ? flipped : din;

endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen #(
  parameter int PAGES = 20,
  parameter int COLS  = 240,
  parameter int DW    = 8,
  localparam int PW   = $clog2(PAGES),
  localparam int CW   = $clog2(COLS),
  localparam int AW   = $clog2(PAGES * COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_stb,
  input  logic [3:0]    cfg_val,
  input  logic          set_page_stb,
  input  logic [PW-1:0] set_page_val,
  input  logic          set_col_stb,
  input  logic [CW-1:0] set_col_val,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic [PW-1:0] cur_page,
  output logic [CW-1:0] cur_col
);
  import dram_pkg::*;

  localparam logic [AW-1:0] ADDR_MAX = AW'(PAGES * COLS - 1);

  mode_t         mode_q;
  logic [AW-1:0] lin_addr;
  logic [DW-1:0] ordered;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_RESET;
    else if (cfg_stb) mode_q <= mode_t'(cfg_val);
  end

  dram_cursor #(.PAGES(PAGES), .COLS(COLS)) cursor_i (
    .clk        (clk),
    .rst        (rst),
    .ld_page    (set_page_stb),
    .ld_page_val(set_page_val),
    .ld_col     (set_col_stb),
    .ld_col_val (set_col_val),
    .adv        (wr_stb),
    .wrap_en    (mode_q.wrap),
    .step_down  (mode_q.page_down),
    .page       (cur_page),
    .col        (cur_col)
  );

  dram_addr_map #(.PAGES(PAGES), .COLS(COLS)) map_i (
    .page  (cur_page),
    .col   (cur_col),
    .mirror(mode_q.mirror),
    .addr  (lin_addr)
  );

  dram_bit_order #(.DW(DW)) order_i (
    .din    (wr_data),
    .reverse(mode_q.rev_bits),
    .dout   (ordered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= wr_stb;
      if (wr_stb) begin
        ram_addr  <= lin_addr;
        ram_wdata <= ordered;
      end
    end
  end

  assert_we_follow_R9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> ram_we);
  assert_we_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !ram_we);
  assert_addr_range_R9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_addr <= ADDR_MAX);
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_stb |=> $stable(mode_q));

endmodule

// File: tb/dram_addr_gen_tb.sv
`timescale 1ns/1ps
module dram_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_stb, set_page_stb, set_col_stb, wr_stb;
  logic [3:0]  cfg_val;
  logic [4:0]  set_page_val;
  logic [7:0]  set_col_val, wr_data;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [4:0]  cur_page;
  logic [7:0]  cur_col;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dram_addr_gen dut_i (
    .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_val(cfg_val),
    .set_page_stb(set_page_stb), .set_page_val(set_page_val),
    .set_col_stb(set_col_stb), .set_col_val(set_col_val),
    .wr_stb(wr_stb), .wr_data(wr_data), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cur_page(cur_page), .cur_col(cur_col)
  );

  // op: 0 load page, 1 load column, 2 write byte, 3 load mode
  // fields: op[51:50] arg[49:42] data[41:34] page[33:29] col[28:21] addr[20:8] wdata[7:0]
  localparam int NV = 18;
  localparam logic [51:0] VEC [0:NV-1] = '{
    {2'd0, 8'd3,   8'h00, 5'd3,  8'd0,   13'd0,    8'h00}, // R2 load page
    {2'd1, 8'd238, 8'h00, 5'd3,  8'd238, 13'd0,    8'h00}, // R2 load column, R3 no advance
    {2'd2, 8'd0,   8'hA1, 5'd3,  8'd239, 13'd958,  8'hA1}, // R3 R9 advance
    {2'd2, 8'd0,   8'h0F, 5'd3,  8'd239, 13'd959,  8'h0F}, // R4 stop at end
    {2'd3, 8'd1,   8'h00, 5'd3,  8'd239, 13'd0,    8'h00}, // R10 wrap on
    {2'd2, 8'd0,   8'h55, 5'd4,  8'd0,   13'd959,  8'h55}, // R5 wrap up
    {2'd0, 8'd25,  8'h00, 5'd19, 8'd0,   13'd0,    8'h00}, // R2 page clamp
    {2'd1, 8'd250, 8'h00, 5'd19, 8'd239, 13'd0,    8'h00}, // R2 column clamp
    {2'd2, 8'd0,   8'h33, 5'd0,  8'd0,   13'd4799, 8'h33}, // R6 top wrap
    {2'd3, 8'd3,   8'h00, 5'd0,  8'd0,   13'd0,    8'h00}, // R10 wrap down
    {2'd1, 8'd239, 8'h00, 5'd0,  8'd239, 13'd0,    8'h00}, // R2
    {2'd2, 8'd0,   8'h01, 5'd19, 8'd0,   13'd239,  8'h01}, // R5 R6 bottom wrap
    {2'd3, 8'd12,  8'h00, 5'd19, 8'd0,   13'd0,    8'h00}, // R10 mirror+reverse
    {2'd2, 8'd0,   8'h01, 5'd19, 8'd1,   13'd4799, 8'h80}, // R7 R8
    {2'd2, 8'd0,   8'h12, 5'd19, 8'd2,   13'd4798, 8'h48}, // R7 R8
    {2'd3, 8'd15,  8'h00, 5'd19, 8'd2,   13'd0,    8'h00}, // R10 all on
    {2'd1, 8'd239, 8'h00, 5'd19, 8'd239, 13'd0,    8'h00}, // R2
    {2'd2, 8'd0,   8'hF0, 5'd18, 8'd0,   13'd4560, 8'h0F}  // R5 R7 R8 down wrap mirrored
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_stb = 0; set_page_stb = 0; set_col_stb = 0; wr_stb = 0;
    cfg_val = '0; set_page_val = '0; set_col_val = '0; wr_data = '0;
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] arg, input logic [7:0] dat);
    idle_inputs();
    case (op)
      2'd0: begin set_page_stb = 1; set_page_val = arg[4:0]; end
      2'd1: begin set_col_stb = 1; set_col_val = arg; end
      2'd2: begin wr_stb = 1; wr_data = dat; end
      default: begin cfg_stb = 1; cfg_val = arg[3:0]; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 reset we", int'(ram_we), 0);
    rst = 0;
    @(negedge clk);
    check("R1 reset page", int'(cur_page), 0);
    check("R1 reset col", int'(cur_col), 0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      step(v[51:50], v[49:42], v[41:34]);
      check("R2/R3/R4/R5/R6 page", int'(cur_page), int'(v[33:29]));
      check("R2/R3/R4/R5/R6 col", int'(cur_col), int'(v[28:21]));
      check("R9 write enable", int'(ram_we), int'(v[51:50] == 2'd2));
      if (v[51:50] == 2'd2) begin
        check("R7/R9 address", int'(ram_addr), int'(v[20:8]));
        check("R8 data", int'(ram_wdata), int'(v[7:0]));
      end
    end

    // R3 priority: load column with a write; write uses old cursor (page 18 col 0, mirrored)
    idle_inputs();
    wr_stb = 1; wr_data = 8'h00; set_col_stb = 1; set_col_val = 8'd10;
    @(negedge clk);
    idle_inputs();
    check("R3 priority we", int'(ram_we), 1);
    check("R3 priority addr", int'(ram_addr), 4559);
    check("R3 priority col", int'(cur_col), 10);
    check("R3 priority page", int'(cur_page), 18);
    @(negedge clk);
    check("R9 single pulse", int'(ram_we), 0);
    check("R3 idle hold", int'(cur_col), 10);

    // R1 reset mid-run clears cursor and mode
    rst = 1;
    @(negedge clk);
    check("R1 we in reset", int'(ram_we), 0);
    rst = 0;
    check("R1 page after reset", int'(cur_page), 0);
    check("R1 col after reset", int'(cur_col), 0);
    step(2'd2, 8'd0, 8'h01);
    check("R1 mode cleared addr", int'(ram_addr), 0);
    check("R1 mode cleared data", int'(ram_wdata), 1);
    check("R1 col advance", int'(cur_col), 1);

    // R4 with cleared mode: stop at end
    step(2'd1, 8'd239, 8'h00);
    step(2'd2, 8'd0, 8'h02);
    check("R4 stop col", int'(cur_col), 239);
    check("R4 stop page", int'(cur_page), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule